// File: doc/BRIEF.md
# Contact Smart Card Power Sequencer

This block powers a contact smart card up and down in the order a cold reset needs. Firmware selects the on-chip card interface and writes a nonzero supply-voltage code. The block then turns on the card supply and waits for a supply-good signal, within a programmable timeout. It releases the I/O line high, then starts the card clock, then releases RST after a programmable number of card clocks. Once RST is released, it times the answer to reset.

Card removal, over-current or a firmware command tears the session down in a fixed order: RST first, then CLK, then I/O with the two auxiliary contacts, and the supply last. The interrupt is raised only after the supply is off. Every interval is counted on a card-clock enable tick (`tick`), which stands in for the clock divider. Sticky flags record why a sequence ended and are cleared by writing ones.

Top module: `sc_power_seq`

## Requirements
- R1: After reset, `vcc_en`, `card_io_en`, `card_clk_run`, `card_rst`, `aux_out`, `irq` and `deact_done` are 0, `flags` is 0 and `status` is 0 (idle).
- R2: Activation (`vcc_en` rising) starts only when `if_sel` is 1 and `vsel` is nonzero. The block never clears `vsel`. After any activation, `vsel` must be seen at zero before another activation can start.
- R3: With `ready_mode`=0, if `supply_ok` is still 0 when `sup_lim` ticks have passed since `vcc_en` rose, the block deactivates without releasing I/O. It sets `flags[0]`, and `vcc_en` falls 6 ticks after it rose when `sup_lim`=3.
- R4: `card_io_en` rises on the 2nd tick after the ready condition. With `ready_mode`=0 that condition is supply timer expiry with `supply_ok` high, so the delay is `sup_lim`+2 ticks after `vcc_en` rises. With `ready_mode`=1 the condition is `supply_ok` alone, so the delay is 2 ticks.
- R5: `card_clk_run` rises 2 ticks after `card_io_en` rises.
- R6: `card_rst` (1 = released) rises `rst_len` ticks after `card_clk_run` rises. `status` is 5 while the answer timer runs.
- R7: While `hold_rst` is 1, `card_rst` is 0 and the clock keeps running. After `hold_rst` clears, `card_rst` rises `rst_len` ticks later.
- R8: If `ts_seen` does not arrive within `atr_lim` ticks of RST release, the block sets `flags[1]` and pulses `irq` exactly `atr_lim` ticks after the release. A `ts_seen` pulse before that moves `status` to 6 (session) with no flag.
- R9: Card removal (`card_present`=0) or `overcurrent` during any active state starts deactivation. Removal sets `flags[2]` and over-current sets `flags[3]`. `irq` and `deact_done` pulse together only once `vcc_en` is already 0.
- R10: A deactivation, from a fault or from `deact_cmd`, drops `card_rst` first. `card_clk_run`, then `card_io_en`, then `vcc_en` follow, each exactly one tick after the one before. `deact_done` comes one tick after `vcc_en` falls. `status` reads 8 at the first step.
- R11: When a fault and `ts_seen` arrive in the same cycle, the fault wins: the next state is 8, not 6.
- R12: Writing 1 to a bit of `clr_flags` clears that sticky flag.
- R13: `aux_out` follows `aux_in` only while `card_io_en` is 1, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Card-clock enable, one cycle per card clock |
| if_sel | input | 1 | On-chip card interface selected |
| vsel | input | 2 | Supply-voltage code, nonzero requests power |
| ready_mode | input | 1 | 0: I/O waits for timer expiry and supply good; 1: supply good alone |
| supply_ok | input | 1 | Card supply within tolerance |
| card_present | input | 1 | Card detected in the slot |
| overcurrent | input | 1 | Supply over-current detected |
| hold_rst | input | 1 | Firmware holds card RST low |
| deact_cmd | input | 1 | Firmware deactivation request, one-cycle pulse |
| ts_seen | input | 1 | Start byte of the answer to reset received |
| sup_lim | input | CW | Supply timeout in ticks |
| rst_len | input | CW | RST release delay in ticks |
| atr_lim | input | CW | Answer-to-reset timeout in ticks |
| aux_in | input | 2 | Requested levels for the C4/C8 contacts |
| clr_flags | input | 4 | Write-one-to-clear for `flags` |
| vcc_en | output | 1 | Card supply enable |
| card_io_en | output | 1 | I/O released high |
| card_clk_run | output | 1 | Card clock running |
| card_rst | output | 1 | Card RST level, 1 = released |
| aux_out | output | 2 | C4/C8 contact levels |
| irq | output | 1 | Interrupt pulse |
| deact_done | output | 1 | Deactivation finished pulse |
| status | output | 4 | State: 0 idle, 1 power, 2 I/O wait, 3 clock wait, 4 reset wait, 5 answer wait, 6 session, 8–11 teardown steps |
| flags | output | 4 | Sticky: [0] supply timeout, [1] answer timeout, [2] removal, [3] over-current |

## Verification
Two things can land in the same cycle. One is a fault; the other is an answer-timer event, either the start byte arriving or the answer timer expiring. The bench drives card removal and `ts_seen` at the same negative edge while the answer timer runs. One edge later it expects the teardown state rather than the session state, and it expects the removal flag but no answer-timeout flag. A second overlap is a firmware reset hold arriving while the session is open. The bench checks that the clock keeps running while RST stays low, and that the release is re-timed from the moment the hold clears.

// File: rtl/sc_power_seq.sv
module sc_power_seq #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          if_sel,
  input  logic [1:0]    vsel,
  input  logic          ready_mode,
  input  logic          supply_ok,
  input  logic          card_present,
  input  logic          overcurrent,
  input  logic          hold_rst,
  input  logic          deact_cmd,
  input  logic          ts_seen,
  input  logic [CW-1:0] sup_lim,
  input  logic [CW-1:0] rst_len,
  input  logic [CW-1:0] atr_lim,
  input  logic [1:0]    aux_in,
  input  logic [3:0]    clr_flags,
  output logic          vcc_en,
  output logic          card_io_en,
  output logic          card_clk_run,
  output logic          card_rst,
  output logic [1:0]    aux_out,
  output logic          irq,
  output logic          deact_done,
  output logic [3:0]    status,
  output logic [3:0]    flags
);
  typedef enum logic [3:0] {
    S_IDLE = 4'd0, S_PWR = 4'd1, S_IOW = 4'd2, S_CKW = 4'd3,
    S_RSTW = 4'd4, S_ATR = 4'd5, S_SESS = 4'd6,
    S_DRST = 4'd8, S_DCLK = 4'd9, S_DIO = 4'd10, S_DVCC = 4'd11
  } st_t;

  localparam logic [CW-1:0] CNT_MAX = '1;
  localparam logic [CW-1:0] CNT_ONE = CW'(1);

  st_t           state, nxt;
  logic [CW-1:0] cnt;
  logic          armed, io_q, clk_q;
  logic          active, sup_exp, go, abort, second_tick;
  logic          vto_evt, atr_evt, end_evt;

  assign active      = state inside {S_PWR, S_IOW, S_CKW, S_RSTW, S_ATR, S_SESS};
  assign sup_exp     = cnt >= sup_lim;
  assign go          = ready_mode ? supply_ok : (sup_exp && supply_ok);
  assign abort       = active && (!card_present || overcurrent || deact_cmd);
  assign second_tick = tick && (cnt == CNT_ONE);

  assign vto_evt = (state == S_PWR) && !go && sup_exp && !abort;
  assign atr_evt = (state == S_ATR) && !abort && !hold_rst && !ts_seen && (cnt >= atr_lim);
  assign end_evt = (state == S_DVCC) && tick;

  always_comb begin
    nxt = state;
    case (state)
      S_IDLE: if (if_sel && vsel != 2'b00 && armed) nxt = S_PWR;
      S_PWR:  if (go) nxt = S_IOW;
              else if (sup_exp) nxt = S_DRST;
      S_IOW:  if (second_tick) nxt = S_CKW;
      S_CKW:  if (second_tick) nxt = S_RSTW;
      S_RSTW: if (!hold_rst && cnt >= rst_len) nxt = S_ATR;
      S_ATR:  if (hold_rst) nxt = S_RSTW;
              else if (ts_seen || cnt >= atr_lim) nxt = S_SESS;
      S_SESS: if (hold_rst) nxt = S_RSTW;
      S_DRST: if (tick) nxt = S_DCLK;
      S_DCLK: if (tick) nxt = S_DIO;
      S_DIO:  if (tick) nxt = S_DVCC;
      S_DVCC: if (tick) nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
    if (abort) nxt = S_DRST;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      cnt        <= '0;
      armed      <= 1'b1;
      io_q       <= 1'b0;
      clk_q      <= 1'b0;
      irq        <= 1'b0;
      deact_done <= 1'b0;
      flags      <= 4'b0000;
    end else begin
      state <= nxt;
      if (nxt != state || (state == S_RSTW && hold_rst)) cnt <= '0;
      else if (tick && cnt != CNT_MAX) cnt <= cnt + CNT_ONE;

      if (state == S_IDLE && nxt == S_PWR) armed <= 1'b0;
      else if (vsel == 2'b00) armed <= 1'b1;

      if (state == S_IOW && nxt == S_CKW) io_q <= 1'b1;
      else if (nxt == S_DIO) io_q <= 1'b0;

      if (state == S_CKW && nxt == S_RSTW) clk_q <= 1'b1;
      else if (nxt == S_DCLK) clk_q <= 1'b0;

      irq        <= atr_evt || end_evt;
      deact_done <= end_evt;
      flags      <= (flags & ~clr_flags) |
                    {active && overcurrent, active && !card_present, atr_evt, vto_evt};
    end
  end

  assign vcc_en       = (state != S_IDLE) && (state != S_DVCC);
  assign card_io_en   = io_q;
  assign card_clk_run = clk_q;
  assign card_rst     = (state == S_ATR) || (state == S_SESS);
  assign aux_out      = io_q ? aux_in : 2'b00;
  assign status       = state;
endmodule

module sc_power_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       if_sel,
  input logic [1:0] vsel,
  input logic       hold_rst,
  input logic       card_present,
  input logic       overcurrent,
  input logic       vcc_en,
  input logic       card_io_en,
  input logic       card_clk_run,
  input logic       card_rst,
  input logic [1:0] aux_out,
  input logic       irq,
  input logic       deact_done
);
  assert_start_cond_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vcc_en) |-> $past(if_sel && vsel != 2'b00));

  assert_io_needs_vcc_R4: assert property (@(posedge clk) disable iff (!rst_n)
    card_io_en |-> vcc_en);

  assert_clk_needs_io_R5: assert property (@(posedge clk) disable iff (!rst_n)
    card_clk_run |-> card_io_en);

  assert_rst_needs_clk_R6: assert property (@(posedge clk) disable iff (!rst_n)
    card_rst |-> (card_clk_run && card_io_en && vcc_en));

  assert_hold_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(card_rst) |-> $past(!hold_rst));

  assert_fault_drops_rst_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (card_rst && (!card_present || overcurrent)) |=> !card_rst);

  assert_irq_after_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    deact_done |-> (irq && !vcc_en));

  assert_supply_last_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vcc_en) |-> $past(!card_rst && !card_clk_run && !card_io_en && aux_out == 2'b00));
endmodule

bind sc_power_seq sc_power_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .if_sel(if_sel), .vsel(vsel), .hold_rst(hold_rst),
  .card_present(card_present), .overcurrent(overcurrent), .vcc_en(vcc_en),
  .card_io_en(card_io_en), .card_clk_run(card_clk_run), .card_rst(card_rst),
  .aux_out(aux_out), .irq(irq), .deact_done(deact_done)
);

// File: tb/tb_sc_power_seq.sv
module tb_sc_power_seq;
  localparam int CW = 8;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic if_sel = 1'b1, ready_mode = 1'b0, supply_ok = 1'b1, card_present = 1'b1;
  logic overcurrent = 1'b0, hold_rst = 1'b0, deact_cmd = 1'b0, ts_seen = 1'b0;
  logic [1:0] vsel = 2'b00, aux_in = 2'b00;
  logic [3:0] clr_flags = 4'b0000;
  logic [CW-1:0] sup_lim = '0, rst_len = '0, atr_lim = '0;
  logic vcc_en, card_io_en, card_clk_run, card_rst, irq, deact_done;
  logic [1:0] aux_out;
  logic [3:0] status, flags;

  sc_power_seq #(.CW(CW)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .if_sel(if_sel), .vsel(vsel),
    .ready_mode(ready_mode), .supply_ok(supply_ok), .card_present(card_present),
    .overcurrent(overcurrent), .hold_rst(hold_rst), .deact_cmd(deact_cmd),
    .ts_seen(ts_seen), .sup_lim(sup_lim), .rst_len(rst_len), .atr_lim(atr_lim),
    .aux_in(aux_in), .clr_flags(clr_flags), .vcc_en(vcc_en), .card_io_en(card_io_en),
    .card_clk_run(card_clk_run), .card_rst(card_rst), .aux_out(aux_out), .irq(irq),
    .deact_done(deact_done), .status(status), .flags(flags));

  always #10 clk = ~clk;

  int ph = 0, ntick = 0, total = 0, fails = 0, irq_live = 0;
  int t_vcc_r, t_io_r, t_clk_r, t_rst_r, t_rst_f, t_clk_f, t_io_f, t_vcc_f, t_irq;
  logic p_vcc = 0, p_io = 0, p_clk = 0, p_rst = 0;

  always @(negedge clk) begin
    ph = (ph + 1) % 4;
    tick = (ph == 0);
  end
  always @(posedge clk) if (tick) ntick++;

  always @(negedge clk) begin
    if (vcc_en && !p_vcc) t_vcc_r = ntick;
    if (!vcc_en && p_vcc) t_vcc_f = ntick;
    if (card_io_en && !p_io) t_io_r = ntick;
    if (!card_io_en && p_io) t_io_f = ntick;
    if (card_clk_run && !p_clk) t_clk_r = ntick;
    if (!card_clk_run && p_clk) t_clk_f = ntick;
    if (card_rst && !p_rst) t_rst_r = ntick;
    if (!card_rst && p_rst) t_rst_f = ntick;
    if (irq) t_irq = ntick;
    if (irq && vcc_en) irq_live++;
    p_vcc = vcc_en; p_io = card_io_en; p_clk = card_clk_run; p_rst = card_rst;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clear_marks();
    t_vcc_r = -1; t_io_r = -1; t_clk_r = -1; t_rst_r = -1; t_rst_f = -1;
    t_clk_f = -1; t_io_f = -1; t_vcc_f = -1; t_irq = -1; irq_live = 0;
  endtask

  task automatic align();
    do @(posedge clk); while (!tick);
    @(negedge clk);
  endtask

  task automatic wait_done();
    while (!deact_done) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic clear_all_flags();
    clr_flags = 4'hF; @(negedge clk); clr_flags = 4'h0; @(negedge clk);
  endtask

  task automatic chk_teardown(input string tag);
    chk(t_clk_f - t_rst_f == 1, {tag, " R10 clk after rst"}, t_clk_f - t_rst_f, 1);
    chk(t_io_f - t_clk_f == 1, {tag, " R10 io after clk"}, t_io_f - t_clk_f, 1);
    chk(t_vcc_f - t_io_f == 1, {tag, " R10 vcc after io"}, t_vcc_f - t_io_f, 1);
    chk(t_irq - t_vcc_f == 1, {tag, " R9 irq after vcc off"}, t_irq - t_vcc_f, 1);
    chk(irq_live == 0, {tag, " R9 irq while powered"}, irq_live, 0);
  endtask

  task automatic rearm();
    vsel = 2'b00; @(negedge clk); @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    total++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    clear_marks();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk({vcc_en, card_io_en, card_clk_run, card_rst, irq, deact_done} == 6'b0, "R1 outputs idle",
        {vcc_en, card_io_en, card_clk_run, card_rst, irq, deact_done}, 0);
    chk(status == 4'd0 && flags == 4'd0, "R1 status/flags", {status, flags}, 0);

    if_sel = 1'b0; vsel = 2'b10;
    repeat (12) @(negedge clk);
    chk(vcc_en == 1'b0, "R2 no start without if_sel", vcc_en, 0);
    vsel = 2'b00; if_sel = 1'b1;
    repeat (12) @(negedge clk);
    chk(vcc_en == 1'b0, "R2 no start with zero vsel", vcc_en, 0);

    // supply timeout then no re-arm
    clear_marks(); ready_mode = 1'b0; supply_ok = 1'b0; sup_lim = 8'd3;
    align(); vsel = 2'b01;
    wait_done();
    chk(t_vcc_f - t_vcc_r == 6, "R3 timeout teardown", t_vcc_f - t_vcc_r, 6);
    chk(t_io_r == -1, "R3 io never released", t_io_r, -1);
    chk(flags == 4'b0001, "R3 flag", flags, 1);
    supply_ok = 1'b1;
    repeat (40) @(negedge clk);
    chk(vcc_en == 1'b0, "R2 vsel kept nonzero, no restart", vcc_en, 0);
    clear_all_flags();
    chk(flags == 4'b0000, "R12 flags cleared", flags, 0);
    rearm();

    // sweep of ready mode, supply limit and reset length
    for (int rm = 0; rm < 2; rm++)
      for (int sl = 0; sl < 4; sl++)
        for (int rl = 0; rl < 4; rl++) begin
          clear_marks();
          ready_mode = rm[0]; sup_lim = CW'(sl); rst_len = CW'(rl); atr_lim = 8'd2;
          align(); vsel = 2'b10;
          while (!card_rst) @(negedge clk);
          chk(status == 4'd5, "R6 answer wait state", status, 5);
          while (!irq) @(negedge clk);
          @(negedge clk);
          chk(t_io_r - t_vcc_r == (rm ? 2 : sl + 2), "R4 io release", t_io_r - t_vcc_r, rm ? 2 : sl + 2);
          chk(t_clk_r - t_io_r == 2, "R5 clock start", t_clk_r - t_io_r, 2);
          chk(t_rst_r - t_clk_r == rl, "R6 rst release", t_rst_r - t_clk_r, rl);
          chk(t_irq - t_rst_r == 2, "R8 answer timeout", t_irq - t_rst_r, 2);
          chk(flags == 4'b0010, "R8 answer flag", flags, 2);
          clear_all_flags();
          chk(flags == 4'b0000, "R12 clear answer flag", flags, 0);
          clear_marks();
          deact_cmd = 1'b1; @(negedge clk); deact_cmd = 1'b0;
          chk(status == 4'd8, "R10 first teardown step", status, 8);
          wait_done();
          chk_teardown("cmd");
          chk(flags == 4'b0000, "R10 command sets no flag", flags, 0);
          rearm();
        end

    // start byte, aux pass-through, hold and re-timed release
    clear_marks(); ready_mode = 1'b1; rst_len = 8'd3; atr_lim = 8'd20; aux_in = 2'b11;
    align(); vsel = 2'b11;
    @(negedge clk);
    chk(aux_out == 2'b00, "R13 aux low before io", aux_out, 0);
    while (!card_rst) @(negedge clk);
    ts_seen = 1'b1; @(negedge clk); ts_seen = 1'b0;
    chk(status == 4'd6, "R8 start byte to session", status, 6);
    chk(aux_out == 2'b11, "R13 aux follows", aux_out, 3);
    aux_in = 2'b01; @(negedge clk);
    chk(aux_out == 2'b01, "R13 aux follows change", aux_out, 1);
    hold_rst = 1'b1; @(negedge clk);
    chk(card_rst == 1'b0 && card_clk_run == 1'b1, "R7 hold drives rst low", {card_rst, card_clk_run}, 1);
    repeat (24) @(negedge clk);
    chk(card_rst == 1'b0, "R7 rst stays low", card_rst, 0);
    begin
      int t_clr;
      hold_rst = 1'b0; t_clr = ntick;
      while (!card_rst) @(negedge clk);
      @(negedge clk);
      chk(t_rst_r - t_clr == 3, "R7 release after hold", t_rst_r - t_clr, 3);
    end
    ts_seen = 1'b1; @(negedge clk); ts_seen = 1'b0;
    chk(flags == 4'b0000, "R8 no flag with start byte", flags, 0);

    // removal during session
    clear_marks();
    card_present = 1'b0; @(negedge clk);
    chk(card_rst == 1'b0 && status == 4'd8, "R9 removal starts teardown", status, 8);
    wait_done();
    chk_teardown("removal");
    chk(aux_out == 2'b00, "R13 aux low after teardown", aux_out, 0);
    chk(flags == 4'b0100, "R9 removal flag", flags, 4);
    card_present = 1'b1; clear_all_flags(); rearm();

    // over-current during supply wait
    clear_marks(); ready_mode = 1'b0; sup_lim = 8'd5;
    align(); vsel = 2'b01;
    repeat (6) @(negedge clk);
    overcurrent = 1'b1; @(negedge clk); overcurrent = 1'b0;
    wait_done();
    chk(t_io_r == -1, "R9 io never released", t_io_r, -1);
    chk(flags == 4'b1000, "R9 over-current flag", flags, 8);
    chk(irq_live == 0, "R9 irq after off", irq_live, 0);
    clear_all_flags(); rearm();

    // fault and start byte together
    clear_marks(); ready_mode = 1'b1; rst_len = 8'd1; atr_lim = 8'd20;
    align(); vsel = 2'b10;
    while (!card_rst) @(negedge clk);
    repeat (3) @(negedge clk);
    ts_seen = 1'b1; card_present = 1'b0; @(negedge clk);
    ts_seen = 1'b0;
    chk(status == 4'd8, "R11 fault wins over start byte", status, 8);
    wait_done();
    chk(flags == 4'b0100, "R11 removal only", flags, 4);
    card_present = 1'b1; clear_all_flags(); rearm();

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule